// File: doc/BRIEF.md
# Parity-Dependent Serial Bit Clock Divider

This block derives the bit clock for a serial engine from one of two input clocks. A source select picks either a fixed divide-by-four of the system clock or an external clock pin. The external pin passes through a two-flop synchronizer and an edge detector, so all logic runs on the single system clock. An 8-bit divide value N sets the output period to N+1 input periods. The split between the high and low phases depends on whether N is even or odd. With N equal to zero the output follows the input clock level directly.

Besides the clock level, the block gives a one-cycle strobe on each rising and each falling output transition. The serial engine can use these strobes to launch and capture data. A change to the divide value is held back until the next rising boundary of the output clock. The period in progress therefore always finishes with its old shape.

Top module: `serclk_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, clk_o, rise_o and fall_o are 0.
- R2: For N > 0, one output period lasts N+1 input-clock periods.
- R3: For an even N > 0, the high phase lasts N/2+1 input periods and the low phase lasts N/2 input periods.
- R4: For an odd N, the high and low phases each last (N+1)/2 input periods.
- R5: For N = 0, clk_o follows the input clock level. Each output phase then equals the matching input phase: 2 system cycles each with the internal source.
- R6: With src_sel_i = 1 the input clock is the system clock divided by four, a period of 4 system cycles. With src_sel_i = 0 it is ext_clk_i after synchronization, with the external period kept.
- R7: A new div_i value is taken only at the rising boundary that ends the current output period. The period in progress completes with the old high and low lengths.
- R8: rise_o is 1 exactly in the first system cycle in which clk_o is 1. fall_o is 1 exactly in the first cycle in which clk_o is 0. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 1 | 1: system clock / 4, 0: external clock |
| ext_clk_i | input | 1 | External input clock, asynchronous |
| div_i | input | 8 | Divide value N |
| clk_o | output | 1 | Generated bit clock level |
| rise_o | output | 1 | One-cycle strobe on a rising transition of clk_o |
| fall_o | output | 1 | One-cycle strobe on a falling transition of clk_o |

## Verification
An input-clock rising edge reaches clk_o one system cycle after it is seen. For the external source, the two synchronizer cycles come before that. Each strobe is registered in the same edge as the clk_o transition it marks. The bench therefore measures phase lengths as run lengths of clk_o sampled on the falling system clock edge, and so never depends on absolute latency. It checks each strobe against the first sample of the phase it marks. After every divide or source change, the bench waits two full output periods before it measures. The exception is the R7 test, which changes the divide value on purpose right after a rising strobe and then expects one old-shaped period followed by a new-shaped one.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int unsigned DIV_W = 8;

  // high phase in input periods: floor(N/2)+1 covers both parities
  function automatic logic [DIV_W-1:0] hi_len(input logic [DIV_W-1:0] n);
    return (n >> 1) + DIV_W'(1);
  endfunction
endpackage

// File: rtl/sclk_src_stage.sv
module sclk_src_stage #(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic ext_clk_i,
  output logic lvl_o,
  output logic rise_o
);
  localparam int unsigned PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX  = PRE_W'(PRESCALE - 1);
  localparam logic [PRE_W-1:0] PRE_HALF = PRE_W'(PRESCALE / 2);

  logic [PRE_W-1:0]  pre_q;
  logic [SYNC_N-1:0] sync_q;
  logic              lvl, lvl_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pre_q <= '0;
    else if (pre_q == PRE_MAX) pre_q <= '0;
    else                      pre_q <= pre_q + PRE_W'(1);
  end

  generate
    if (SYNC_N > 1) begin : g_sync_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_N-2:0], ext_clk_i};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ext_clk_i;
      end
    end
  endgenerate

  assign lvl = sel_i ? (pre_q >= PRE_HALF) : sync_q[SYNC_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= 1'b0;
    else         lvl_d_q <= lvl;
  end

  assign lvl_o  = lvl;
  assign rise_o = lvl & ~lvl_d_q;

  // R6: internal source never yields back-to-back input edges
  a_r6_int_edge_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && $past(sel_i) && rise_o) |=> !rise_o);
endmodule

// File: rtl/sclk_phase_ctr.sv
module sclk_phase_ctr
  import sclk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] div_q, div_n;
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             out_q, out_n;
  logic             rise_q, fall_q;

  always_comb begin
    div_n = div_q;
    cnt_n = cnt_q;
    out_n = out_q;
    if (rise_i) begin
      if (div_q == '0 || cnt_q == div_q) begin
        // period boundary: safe point to take a new divide value
        div_n = div_i;
        cnt_n = '0;
        out_n = 1'b1;
      end else begin
        cnt_n = cnt_q + DIV_W'(1);
        out_n = (cnt_n < hi_len(div_q));
      end
    end
    if (div_q == '0) out_n = lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      div_q  <= div_n;
      cnt_q  <= cnt_n;
      out_q  <= out_n;
      rise_q <= out_n & ~out_q;
      fall_q <= ~out_n & out_q;
    end
  end

  assign clk_o  = out_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R7: divide value only moves on an input edge
  a_r7_div_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_q) |-> $past(rise_i));
  // R2: counter never runs past the period length
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != '0) |-> (cnt_q <= div_q));
  // R3: in divide mode the output only toggles on an input edge
  a_r3_toggle_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(div_q) != '0 && clk_o != $past(clk_o)) |-> $past(rise_i));
  // R8: strobes exclusive
  a_r8_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
  import sclk_div_pkg::*;
#(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_sel_i,
  input  logic             ext_clk_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic in_lvl, in_rise;

  sclk_src_stage #(.PRESCALE(PRESCALE), .SYNC_N(SYNC_N)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (src_sel_i),
    .ext_clk_i(ext_clk_i),
    .lvl_o    (in_lvl),
    .rise_o   (in_rise)
  );

  sclk_phase_ctr u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (in_lvl),
    .rise_i(in_rise),
    .div_i (div_i),
    .clk_o (clk_o),
    .rise_o(rise_o),
    .fall_o(fall_o)
  );

  // R1: outputs quiet on the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!clk_o && !rise_o && !fall_o));
endmodule

// File: tb/serclk_gen_tb.sv
module serclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b1;
  logic       ext_clk = 1'b0;
  logic [7:0] div = 8'd0;
  logic       clk_o, rise_o, fall_o;
  int checks = 0;
  int errors = 0;
  int serr   = 0;

  always #5 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  serclk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(sel), .ext_clk_i(ext_clk),
    .div_i(div), .clk_o(clk_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stop at the first negedge sample where clk_o is newly high
  task automatic align();
    logic p;
    p = clk_o;
    forever begin
      @(negedge clk);
      if (clk_o && !p) break;
      p = clk_o;
    end
  endtask

  // assumes current sample is first high sample; ends on next one
  task automatic measure_one(input int eh, input int el, input string tag);
    int hi = 0;
    int lo = 0;
    while (clk_o) begin
      if (rise_o != (hi == 0)) serr++;
      if (fall_o) serr++;
      hi++;
      @(negedge clk);
    end
    while (!clk_o) begin
      if (fall_o != (lo == 0)) serr++;
      if (rise_o) serr++;
      lo++;
      @(negedge clk);
    end
    check(hi == eh, {tag, " high"}, hi, eh);
    check(lo == el, {tag, " low"}, lo, el);
    check(hi + lo == eh + el, {tag, " period R2"}, hi + lo, eh + el);
  endtask

  task automatic run_div(input logic s, input logic [7:0] d, input int eh,
                         input int el, input string tag);
    sel = s;
    div = d;
    align(); align(); align();
    measure_one(eh, el, tag);
    measure_one(eh, el, tag);
  endtask

  task automatic test_reset();
    check(!clk_o && !rise_o && !fall_o, "R1 reset outputs", {clk_o, rise_o, fall_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!clk_o && !rise_o && !fall_o, "R1 first cycle", {clk_o, rise_o, fall_o}, 0);
  endtask

  task automatic test_late_change();
    sel = 1'b1; div = 8'd4;
    align(); align(); align();
    div = 8'd7;
    measure_one(12, 8, "R7 old shape");
    measure_one(16, 16, "R7 new shape");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    run_div(1'b1, 8'd0,   2,   2,   "R5 internal pass-through");
    run_div(1'b1, 8'd1,   4,   4,   "R4 R6 div1 internal");
    run_div(1'b1, 8'd3,   8,   8,   "R4 div3");
    run_div(1'b1, 8'd4,   12,  8,   "R3 div4");
    run_div(1'b1, 8'd2,   8,   4,   "R3 div2");
    run_div(1'b1, 8'd255, 512, 512, "R4 div255");
    test_late_change();
    run_div(1'b0, 8'd2,   12,  6,   "R6 external div2");
    run_div(1'b0, 8'd0,   3,   3,   "R5 R6 external pass-through");
    check(serr == 0, "R8 strobe alignment", serr, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule